// File: doc/BRIEF.md
# GPIO External Interrupt Router

This block turns pin transitions on a bank of GPIO ports into interrupt requests. It has sixteen interrupt lines. Line n always watches pin n, and software chooses which port that pin is taken from. Each line can be armed for rising edges, falling edges or both. An armed edge on the watched pin sets a sticky flag for that line. A flag is cleared only by software, and software may also set a flag on purpose.

The pin levels arrive already synchronized as one flat vector, ports side by side with sixteen pins each. Software reaches the block through a simple word-wide register bus: one write strobe, and read data that follows the address within the same cycle. The flags are gated by an enable mask and then combined into two interrupt requests. One request collects the even-numbered lines and the other collects the odd-numbered lines. Level-style retriggering is left to the interrupt handler, which can raise a flag through the set alias.

Top module: `ext_irq_router`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0 and both interrupt outputs are low.
- R2: Port selects live at 0x100 (lines 0–7) and 0x104 (lines 8–15). Each line owns four bits starting at bit 4·(n mod 8), and all 32 bits read back as written. The rising-edge mask (0x108), the falling-edge mask (0x10C) and the enable mask (0x110) keep bits 15:0, and their bits 31:16 read as 0. Any other address reads 0.
- R3: Line n samples bit p·16+n of the pin vector, where p is the low three bits of its select field. A select value of 6 or 7 names no port, and the line then sees a constant 0.
- R4: A 0→1 change of the watched pin with the line's rising-mask bit at 1, or a 1→0 change with its falling-mask bit at 1, sets the flag at the clock edge that first samples the new level.
- R5: A set flag stays set until software clears it, even after its edge mask bits return to 0. An edge whose mask bit is 0 does not set the flag.
- R6: The flags read at 0x114, where bits 31:16 read 0 and writes have no effect. Writing 1s to 0x118 sets those flags, and writing 1s to 0x11C clears them. 0 bits in either write leave their flags unchanged.
- R7: If an armed edge occurs in the same cycle as a software clear of that flag, the flag ends up set.
- R8: Changing a line's port select does not by itself set its flag, even when the old pin and the new pin differ in level.
- R9: The even output is high exactly when some even line has both its flag and its enable bit at 1. The odd output does the same for the odd lines. Both follow the registers with no added delay.
- R10: Transitions on pins that no line currently watches never set any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 96 | Synchronized pin levels; bit p·16+i is pin i of port p |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_even | output | 1 | Request from the even-numbered lines |
| irq_odd | output | 1 | Request from the odd-numbered lines |

## Verification
Directed patterns come first. A single rising edge on the watched pin must set its flag while the same transition on another port must not, which separates correct routing from a pin mix-up. A falling edge with only the falling mask armed checks that the two edge types are kept apart. Further directed cases reselect a port between pins at different levels, which exposes a spurious edge, and collide a hardware edge with a software clear, which exposes the wrong priority. Random pin vectors under random edge and enable masks are then compared cycle by cycle with a flag model. That comparison catches inverted edge polarity, wrong even/odd grouping and lost stickiness.

// File: rtl/eir_pkg.sv
package eir_pkg;

    localparam int NUM_LINES     = 16;
    localparam int NUM_PORTS     = 6;
    localparam int PINS_PER_PORT = 16;
    localparam int ADDR_W        = 12;
    localparam int DATA_W        = 32;
    localparam int SEL_FIELD_W   = 4;
    localparam int PORT_IDX_W    = 3;
    localparam int FIELDS_PER_WORD = DATA_W / SEL_FIELD_W;

    localparam logic [ADDR_W-1:0] A_SEL_LO = 12'h100;
    localparam logic [ADDR_W-1:0] A_SEL_HI = 12'h104;
    localparam logic [ADDR_W-1:0] A_RISE   = 12'h108;
    localparam logic [ADDR_W-1:0] A_FALL   = 12'h10C;
    localparam logic [ADDR_W-1:0] A_ENABLE = 12'h110;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 12'h114;
    localparam logic [ADDR_W-1:0] A_FSET   = 12'h118;
    localparam logic [ADDR_W-1:0] A_FCLR   = 12'h11C;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_SEL_LO,
        RG_SEL_HI,
        RG_RISE,
        RG_FALL,
        RG_ENABLE,
        RG_FLAGS,
        RG_FSET,
        RG_FCLR
    } reg_id_e;

    typedef struct packed {
        logic [PORT_IDX_W-1:0] port;
        logic                  rise;
        logic                  fall;
    } line_cfg_t;

    function automatic reg_id_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_id_e r;
        case (a)
            A_SEL_LO: r = RG_SEL_LO;
            A_SEL_HI: r = RG_SEL_HI;
            A_RISE:   r = RG_RISE;
            A_FALL:   r = RG_FALL;
            A_ENABLE: r = RG_ENABLE;
            A_FLAGS:  r = RG_FLAGS;
            A_FSET:   r = RG_FSET;
            A_FCLR:   r = RG_FCLR;
            default:  r = RG_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [PORT_IDX_W-1:0] port_of(input logic [SEL_FIELD_W-1:0] field);
        return field[PORT_IDX_W-1:0];
    endfunction

endpackage

// File: rtl/eir_cfg_regs.sv
module eir_cfg_regs
    import eir_pkg::*;
#(
    parameter int LINES = NUM_LINES,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 bus_we,
    input  logic [LINES-1:0]     flags_i,
    output line_cfg_t [LINES-1:0] cfg_o,
    output logic [LINES-1:0]     enable_o,
    output logic [LINES-1:0]     sw_set_o,
    output logic [LINES-1:0]     sw_clr_o,
    output logic [DW-1:0]        rdata_o
);

    localparam int FPW = DW / SEL_FIELD_W;

    logic [DW-1:0]    sel_lo_q, sel_hi_q;
    logic [LINES-1:0] rise_q, fall_q, enable_q;
    reg_id_e          reg_id;

    assign reg_id = decode_addr(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_lo_q <= '0;
            sel_hi_q <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            enable_q <= '0;
        end else if (bus_we) begin
            case (reg_id)
                RG_SEL_LO: sel_lo_q <= bus_wdata;
                RG_SEL_HI: sel_hi_q <= bus_wdata;
                RG_RISE:   rise_q   <= bus_wdata[LINES-1:0];
                RG_FALL:   fall_q   <= bus_wdata[LINES-1:0];
                RG_ENABLE: enable_q <= bus_wdata[LINES-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        sw_set_o = '0;
        sw_clr_o = '0;
        if (bus_we && reg_id == RG_FSET) sw_set_o = bus_wdata[LINES-1:0];
        if (bus_we && reg_id == RG_FCLR) sw_clr_o = bus_wdata[LINES-1:0];
    end

    for (genvar n = 0; n < LINES; n++) begin : g_cfg
        if (n < FPW) begin : g_lo
            assign cfg_o[n].port = port_of(sel_lo_q[SEL_FIELD_W*n +: SEL_FIELD_W]);
        end else begin : g_hi
            assign cfg_o[n].port = port_of(sel_hi_q[SEL_FIELD_W*(n-FPW) +: SEL_FIELD_W]);
        end
        assign cfg_o[n].rise = rise_q[n];
        assign cfg_o[n].fall = fall_q[n];
    end

    assign enable_o = enable_q;

    always_comb begin
        case (reg_id)
            RG_SEL_LO: rdata_o = sel_lo_q;
            RG_SEL_HI: rdata_o = sel_hi_q;
            RG_RISE:   rdata_o = DW'(rise_q);
            RG_FALL:   rdata_o = DW'(fall_q);
            RG_ENABLE: rdata_o = DW'(enable_q);
            RG_FLAGS:  rdata_o = DW'(flags_i);
            default:   rdata_o = '0;
        endcase
    end

    // R1: configuration is empty the cycle after reset
    p_reset_cfg_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_lo_q == '0 && sel_hi_q == '0 && rise_q == '0 &&
                        fall_q == '0 && enable_q == '0));

    // R6: a write to the set alias leaves every written bit set in the flags
    p_set_alias_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_FSET) |=>
            ((flags_i & $past(bus_wdata[LINES-1:0])) == $past(bus_wdata[LINES-1:0])));

    // R2: masks never hold bits above the line count on readback
    p_mask_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_RISE || bus_addr == A_FALL || bus_addr == A_ENABLE) |->
            rdata_o[DW-1:LINES] == '0);

endmodule

// File: rtl/eir_line.sv
module eir_line
    import eir_pkg::*;
#(
    parameter int PORTS = NUM_PORTS,
    parameter int PW    = PORT_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PORTS-1:0] pin_col,
    input  logic [PW-1:0]    port_sel,
    input  logic             rise_en,
    input  logic             fall_en,
    input  logic             sw_set,
    input  logic             sw_clr,
    output logic             flag_o
);

    logic          cur_lvl;
    logic          prev_q;
    logic          armed_q;
    logic [PW-1:0] sel_seen_q;
    logic          flag_q;
    logic          reload;
    logic          hw_set;

    always_comb begin
        cur_lvl = 1'b0;
        for (int p = 0; p < PORTS; p++) begin
            if (port_sel == PW'(p)) cur_lvl = pin_col[p];
        end
    end

    assign reload = !armed_q || (port_sel != sel_seen_q);
    assign hw_set = !reload &&
                    ((rise_en && cur_lvl && !prev_q) ||
                     (fall_en && !cur_lvl && prev_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= 1'b0;
            armed_q    <= 1'b0;
            sel_seen_q <= '0;
            flag_q     <= 1'b0;
        end else begin
            prev_q     <= cur_lvl;
            armed_q    <= 1'b1;
            sel_seen_q <= port_sel;
            flag_q     <= hw_set || sw_set || (flag_q && !sw_clr);
        end
    end

    assign flag_o = flag_q;

    // R5: a set flag survives until a clear arrives
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !sw_clr) |=> flag_q);

    // R7: a detected edge beats a simultaneous clear
    p_hw_wins_r7: assert property (@(posedge clk) disable iff (rst)
        hw_set |=> flag_q);

    // R6: a clear with nothing setting leaves the flag low
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && !hw_set && !sw_set) |=> !flag_q);

    // R8: a port reselection alone does not raise the flag
    p_reselect_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !sw_set && port_sel != $past(port_sel)) |=> !flag_q);

endmodule

// File: rtl/eir_irq_split.sv
module eir_irq_split #(
    parameter int LINES = eir_pkg::NUM_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] flags_i,
    input  logic [LINES-1:0] enable_i,
    output logic             irq_even_o,
    output logic             irq_odd_o
);

    logic [LINES-1:0] even_mask, odd_mask, pending;

    for (genvar n = 0; n < LINES; n++) begin : g_par
        assign even_mask[n] = (n % 2 == 0);
        assign odd_mask[n]  = (n % 2 == 1);
    end

    assign pending    = flags_i & enable_i;
    assign irq_even_o = |(pending & even_mask);
    assign irq_odd_o  = |(pending & odd_mask);

    // R9: with every enable off neither request can be raised
    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (enable_i == '0) |-> (!irq_even_o && !irq_odd_o));

endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
    import eir_pkg::*;
#(
    parameter int LINES  = NUM_LINES,
    parameter int PORTS  = NUM_PORTS,
    parameter int PPORT  = PINS_PER_PORT,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PORTS*PPORT-1:0] pin_lvl,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    input  logic                   bus_we,
    output logic [DW-1:0]          bus_rdata,
    output logic                   irq_even,
    output logic                   irq_odd
);

    line_cfg_t [LINES-1:0] cfg;
    logic [LINES-1:0]      enable, sw_set, sw_clr, flags;

    eir_cfg_regs #(.LINES(LINES), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .flags_i   (flags),
        .cfg_o     (cfg),
        .enable_o  (enable),
        .sw_set_o  (sw_set),
        .sw_clr_o  (sw_clr),
        .rdata_o   (bus_rdata)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        logic [PORTS-1:0] col;
        for (genvar p = 0; p < PORTS; p++) begin : g_col
            assign col[p] = pin_lvl[p*PPORT + n];
        end
        eir_line #(.PORTS(PORTS), .PW(PORT_IDX_W)) u_line (
            .clk      (clk),
            .rst      (rst),
            .pin_col  (col),
            .port_sel (cfg[n].port),
            .rise_en  (cfg[n].rise),
            .fall_en  (cfg[n].fall),
            .sw_set   (sw_set[n]),
            .sw_clr   (sw_clr[n]),
            .flag_o   (flags[n])
        );
    end

    eir_irq_split #(.LINES(LINES)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .flags_i    (flags),
        .enable_i   (enable),
        .irq_even_o (irq_even),
        .irq_odd_o  (irq_odd)
    );

    // R1: both requests are low right after reset
    p_reset_irq_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_even && !irq_odd));

endmodule

// File: tb/test_ext_irq_router.sv
module test_ext_irq_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [95:0] pin_lvl = '0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_even, irq_odd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_sel_lo, m_sel_hi;
    logic [15:0] m_rise, m_fall, m_en, m_flags;

    always #10 clk = ~clk;

    ext_irq_router i_ext_irq_router (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .irq_even(irq_even), .irq_odd(irq_odd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic watched(input logic [95:0] pins, input int line);
        logic [2:0] port;
        port = (line < 8) ? m_sel_lo[4*line +: 3] : m_sel_hi[4*(line-8) +: 3];
        return (port < 6) ? pins[port*16 + line] : 1'b0;
    endfunction

    function automatic logic [1:0] exp_irq(input logic [15:0] f, input logic [15:0] e);
        return {|(f & e & 16'hAAAA), |(f & e & 16'h5555)};
    endfunction

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [95:0] prev_pins, nxt;
        void'($urandom(32'h5EED_1234));
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        rd(12'h100, d); chk("R1 sel_lo", d, 0);
        rd(12'h104, d); chk("R1 sel_hi", d, 0);
        rd(12'h110, d); chk("R1 enable", d, 0);
        rd(12'h114, d); chk("R1 flags", d, 0);
        chk("R1 irq", {30'b0, irq_odd, irq_even}, 0);

        // R2: readback and width
        wr(12'h100, 32'hFEDC_BA98); rd(12'h100, d); chk("R2 sel_lo", d, 32'hFEDC_BA98);
        wr(12'h108, 32'hFFFF_FFFF); rd(12'h108, d); chk("R2 rise width", d, 32'h0000_FFFF);
        wr(12'h10C, 32'h1234_5678); rd(12'h10C, d); chk("R2 fall width", d, 32'h0000_5678);
        rd(12'h120, d); chk("R2 unmapped", d, 0);

        // configure routing
        m_sel_lo = 32'h7654_3210; m_sel_hi = 32'h1054_3210;
        wr(12'h100, m_sel_lo); wr(12'h104, m_sel_hi);
        wr(12'h108, 32'hFFFF); wr(12'h10C, 0); wr(12'h110, 0);
        wr(12'h11C, 32'hFFFF);
        idle(2);

        // R10: pin 3 of port 0 is not watched by line 3 (port 3)
        pin_lvl[3] = 1'b1; idle(1);
        rd(12'h114, d); chk("R10 unwatched pin", d, 0);
        // R3: line 6 on code 6 sees constant 0
        pin_lvl[6] = 1'b1; pin_lvl[5*16+6] = 1'b1; idle(1);
        rd(12'h114, d); chk("R3 no-port code", d, 0);
        // R3 R4: line 3 on port 3 -> pin 51 rising
        pin_lvl[51] = 1'b1; idle(1);
        rd(12'h114, d); chk("R4 rising on routed pin R3", d, 32'h0008);

        // R6: clear, set, ignored direct write
        wr(12'h11C, 32'h0008); rd(12'h114, d); chk("R6 clear alias", d, 0);
        wr(12'h118, 32'hFFFF_0020); rd(12'h114, d); chk("R6 set alias", d, 32'h0020);
        wr(12'h114, 32'hFFFF); rd(12'h114, d); chk("R6 flag write ignored", d, 32'h0020);
        wr(12'h11C, 32'hFFFF);

        // R4 R5: falling only
        wr(12'h108, 0); wr(12'h10C, 32'h0008);
        pin_lvl[51] = 1'b1; pin_lvl[2*16+2] = 1'b1; idle(1);
        rd(12'h114, d); chk("R5 masked rising edge", d, 0);
        pin_lvl[51] = 1'b0; idle(1);
        rd(12'h114, d); chk("R4 falling edge", d, 32'h0008);
        wr(12'h10C, 0); idle(2);
        rd(12'h114, d); chk("R5 sticky after mask off", d, 32'h0008);

        // R9: parity outputs
        idle(1); #1 chk("R9 no enables", {30'b0, irq_odd, irq_even}, 0);
        wr(12'h110, 32'h0008); #1 chk("R9 odd line", {30'b0, irq_odd, irq_even}, 32'h2);
        wr(12'h11C, 32'hFFFF); wr(12'h118, 32'h0010); wr(12'h110, 32'h0018);
        #1 chk("R9 even line", {30'b0, irq_odd, irq_even}, 32'h1);
        wr(12'h11C, 32'hFFFF); #1 chk("R9 cleared", {30'b0, irq_odd, irq_even}, 0);
        wr(12'h110, 0);

        // R7: edge beats simultaneous clear on line 2 (pin 34 low->high)
        wr(12'h108, 32'h0004);
        pin_lvl[34] = 1'b0; idle(2);
        wr(12'h118, 32'h0004);
        pin_lvl[34] = 1'b1;
        wr(12'h11C, 32'h0004);
        rd(12'h114, d); chk("R7 set wins", d, 32'h0004);
        wr(12'h11C, 32'hFFFF);

        // R8: line 0 moves from port 0 (low) to port 1 (high)
        pin_lvl[0] = 1'b0; pin_lvl[16] = 1'b1;
        wr(12'h108, 32'h0001); wr(12'h10C, 32'h0001); idle(2);
        wr(12'h100, 32'h7654_3211); idle(2);
        rd(12'h114, d); chk("R8 reselect quiet", d, 0);
        pin_lvl[16] = 1'b0; idle(1);
        rd(12'h114, d); chk("R8 new pin live", d, 32'h0001);

        // random phase
        wr(12'h100, m_sel_lo); idle(2);
        m_flags = 0;
        wr(12'h11C, 32'hFFFF);
        prev_pins = pin_lvl;
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) begin
                m_rise = 16'($urandom); m_fall = 16'($urandom); m_en = 16'($urandom);
                wr(12'h108, {16'b0, m_rise}); wr(12'h10C, {16'b0, m_fall});
                wr(12'h110, {16'b0, m_en}); wr(12'h11C, 32'hFFFF);
                m_flags = 0;
            end
            nxt = {$urandom, $urandom, $urandom};
            for (int n = 0; n < 16; n++) begin
                logic c, p;
                c = watched(nxt, n); p = watched(prev_pins, n);
                if ((m_rise[n] && c && !p) || (m_fall[n] && !c && p)) m_flags[n] = 1'b1;
            end
            pin_lvl = nxt; prev_pins = nxt;
            idle(1);
            rd(12'h114, d); chk("R4 R5 R3 random flags", d, {16'b0, m_flags});
            chk("R9 random irq", {30'b0, irq_odd, irq_even}, {30'b0, exp_irq(m_flags, m_en)});
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule